// File: doc/BRIEF.md
# Transmit Byte Queue with Count-Based Commit

This block is the transmit-side byte store of a high-speed serial port. Host software places outgoing bytes into a 1024-byte address window. Window offset k lands at ring position (write pointer + k). Staged bytes stay invisible to the transmitter until the host writes their count to the control register. That write hands the bytes over in one step, moves the write pointer past them and raises the fill level by the same amount. Reading the same register returns both the write pointer and the fill level. A host can therefore see how much room is left and where its next burst will land, including whether that spot is word aligned.

Committed bytes leave in commit order toward a serial shifter over a valid/ready handshake, one byte per accepted transfer. A space indication is asserted while the fill level is below a threshold chosen by a 3-bit code. An empty indication is asserted while nothing is queued. The serialiser and the baud timing sit outside this block.

Top module: `txq_commit`

## Requirements
- R1: After reset the fill level and the write pointer are zero, tx_valid_o is low and tx_empty_o is high.
- R2: A write to an address in 0x400..0x7FF stores bus_wdata_i[7:0] at ring position (write pointer + address[9:0]) mod DEPTH. It changes neither the fill level nor the write pointer, and the byte is not offered to the transmitter before a commit.
- R3: A write to 0x804 commits N = bus_wdata_i[9:0] bytes. The write pointer advances by N modulo DEPTH and the fill level rises by N.
- R4: The ring holds at most DEPTH-1 bytes. A commit larger than the free space (DEPTH-1 minus fill) is clamped to the free space, and the pointer advances by the clamped amount only.
- R5: A window write whose offset is not below the free space is dropped, so bytes already committed are never overwritten.
- R6: While bus_addr_i is 0x804, bus_rdata_o carries the write pointer in bits [log2(DEPTH)-1:0] and the fill level in bits starting at bit 16, with all other bits zero. Any other address reads zero.
- R7: Bytes leave in the order they were committed. A byte is transferred on each cycle in which tx_valid_o and tx_ready_i are both high, and each transfer lowers the fill level by one.
- R8: tx_valid_o is high exactly when the fill level is non-zero; tx_empty_o is high exactly when it is zero.
- R9: tx_space_o is high exactly when the fill level is below 2^(tx_level_i+2) bytes (code 0 means 4 bytes, code 5 means 128 bytes, code 7 means 512 bytes).
- R10: A commit and a transfer in the same cycle act together: the new fill is the old fill plus the clamped count minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Host write strobe |
| bus_addr_i | input | 12 | Host byte address |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data (control word at 0x804) |
| tx_level_i | input | 3 | Space threshold code |
| tx_data_o | output | 8 | Byte offered to the shifter |
| tx_valid_o | output | 1 | A committed byte is available |
| tx_ready_i | input | 1 | Shifter accepts the byte |
| tx_space_o | output | 1 | Fill level below threshold |
| tx_empty_o | output | 1 | Nothing queued |

## Verification
The bench builds the block with DEPTH set to 64 rather than 1024. This brings clamping, a full ring, dropped window writes and several pointer wraps within a few hundred cycles. With that depth, threshold codes 0 to 3 toggle tx_space_o across the reachable fill range, and codes 4 to 7 pin it high. The random phase mixes staged writes just beyond the free space, oversized commits and bursty ready. This exposes simultaneous commit and transfer cycles as well as writes at the wrap boundary.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int unsigned BUS_AW   = 12;
  localparam int unsigned WIN_AW   = 10;          // window offset and commit count width
  localparam logic [BUS_AW-1:0] CTRL_ADDR = 12'h804;
  localparam logic [1:0]        WIN_TAG   = 2'b01; // addr[11:10] of 0x400..0x7FF
  localparam int unsigned FILL_LSB = 16;

  function automatic logic [31:0] level_bytes(input logic [2:0] code);
    return 32'd1 << (32'(code) + 32'd2);
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stage_we_i,
  input  logic [WIN_AW-1:0] stage_ofs_i,
  input  logic              commit_i,
  input  logic [WIN_AW-1:0] commit_n_i,
  input  logic              pop_i,
  output logic [AW-1:0]     wptr_o,
  output logic [AW-1:0]     rptr_o,
  output logic [AW-1:0]     fill_o,
  output logic              store_we_o,
  output logic [AW-1:0]     store_addr_o
);
  localparam int unsigned MW  = ((AW + 1) > WIN_AW) ? (AW + 1) : WIN_AW;
  localparam logic [MW-1:0] CAP = MW'(DEPTH - 1);

  logic [AW-1:0] wptr_q, rptr_q, fill_q;
  logic [MW-1:0] free_w, req_w, add_w;

  assign free_w = CAP - MW'(fill_q);
  assign req_w  = MW'(commit_n_i);
  assign add_w  = commit_i ? ((req_w > free_w) ? free_w : req_w) : '0;

  // staged bytes must stay clear of committed data
  assign store_we_o   = stage_we_i && (MW'(stage_ofs_i) < free_w);
  assign store_addr_o = wptr_q + AW'(stage_ofs_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(add_w);
      if (pop_i) rptr_q <= rptr_q + 1'b1;
      fill_q <= fill_q + AW'(add_w) - AW'(pop_i);
    end
  end

  assign wptr_o = wptr_q;
  assign rptr_o = rptr_q;
  assign fill_o = fill_q;

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MW'(fill_q) <= CAP);
  a_r7_pop_drops_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !commit_i) |=> (fill_q == $past(fill_q) - 1'b1));
  a_r3_commit_no_shrink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !pop_i) |=> (fill_q >= $past(fill_q)));
  a_r2_stage_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_we_i && !commit_i && !pop_i) |=> ($stable(fill_q) && $stable(wptr_q)));
endmodule

// File: rtl/txq_commit.sv
module txq_commit
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [11:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic [2:0]  tx_level_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic        tx_space_o,
  output logic        tx_empty_o
);
  logic win_hit, ctrl_hit, pop;
  logic [AW-1:0] wptr, rptr, fill, st_addr;
  logic st_we;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31:WIN_AW];

  assign win_hit  = (bus_addr_i[BUS_AW-1:WIN_AW] == WIN_TAG);
  assign ctrl_hit = (bus_addr_i == CTRL_ADDR);
  assign pop      = tx_valid_o && tx_ready_i;

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stage_we_i   (bus_we_i && win_hit),
    .stage_ofs_i  (bus_addr_i[WIN_AW-1:0]),
    .commit_i     (bus_we_i && ctrl_hit),
    .commit_n_i   (bus_wdata_i[WIN_AW-1:0]),
    .pop_i        (pop),
    .wptr_o       (wptr),
    .rptr_o       (rptr),
    .fill_o       (fill),
    .store_we_o   (st_we),
    .store_addr_o (st_addr)
  );

  txq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (st_we),
    .waddr_i (st_addr),
    .wdata_i (bus_wdata_i[7:0]),
    .raddr_i (rptr),
    .rdata_o (tx_data_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (ctrl_hit) begin
      bus_rdata_o[AW-1:0]          = wptr;
      bus_rdata_o[FILL_LSB +: AW]  = fill;
    end
  end

  assign tx_valid_o = (fill != '0);
  assign tx_empty_o = (fill == '0);
  assign tx_space_o = (32'(fill) < level_bytes(tx_level_i));

  a_r8_valid_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !tx_empty_o);
  a_r9_empty_has_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_space_o);
endmodule

// File: tb/txq_commit_tb.sv
`timescale 1ns/1ps
module txq_commit_tb;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = 12'h804;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  tx_level = 3'd0;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready = 1'b0, tx_space, tx_empty;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  byte unsigned m_mem [DEPTH];
  bit           m_known [DEPTH];
  int           m_wptr = 0, m_rptr = 0, m_fill = 0;

  always #4 clk = ~clk;

  txq_commit #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tx_level_i(tx_level),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_space_o(tx_space), .tx_empty_o(tx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return (32'(m_fill) << 16) | 32'(m_wptr);
  endfunction

  function automatic bit exp_space(input int code);
    return m_fill < (1 << (code + 2));
  endfunction

  task automatic status();
    bus_we = 1'b0; bus_addr = 12'h804; tx_ready = 1'b0;
    tx_level = 3'($urandom % 8);
    #1;
    chk("R6 ctrl word", bus_rdata, exp_word());
    chk("R8 empty", 32'(tx_empty), 32'(m_fill == 0));
    chk("R8 valid", 32'(tx_valid), 32'(m_fill != 0));
    chk("R9 space", 32'(tx_space), 32'(exp_space(int'(tx_level))));
  endtask

  // one bus cycle plus optional drain
  task automatic op(input bit we, input logic [11:0] a, input logic [31:0] d, input bit rdy);
    bit pop;
    int free, add, ofs;
    bus_we = we; bus_addr = a; bus_wdata = d; tx_ready = rdy;
    #1;
    pop = rdy && (m_fill != 0);
    if (pop && m_known[m_rptr]) chk("R7 order", 32'(tx_data), 32'(m_mem[m_rptr]));
    @(posedge clk);
    free = DEPTH - 1 - m_fill;
    add  = 0;
    if (we && a[11:10] == 2'b01) begin
      ofs = int'(a[9:0]);
      if (ofs < free) begin
        m_mem[(m_wptr + ofs) % DEPTH]   = d[7:0];
        m_known[(m_wptr + ofs) % DEPTH] = 1'b1;
      end
    end
    if (we && a == 12'h804) add = (int'(d[9:0]) > free) ? free : int'(d[9:0]);
    m_wptr = (m_wptr + add) % DEPTH;
    if (pop) m_rptr = (m_rptr + 1) % DEPTH;
    m_fill = m_fill + add - (pop ? 1 : 0);
    @(negedge clk);
    status();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = 0; m_known[i] = 1'b0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ctrl word", bus_rdata, 32'd0);
    chk("R1 empty", 32'(tx_empty), 32'd1);
    chk("R1 valid", 32'(tx_valid), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    status();

    // R2: staged bytes stay hidden
    op(1'b1, 12'h400, 32'hA1, 1'b1);
    op(1'b1, 12'h401, 32'hB2, 1'b1);
    op(1'b1, 12'h402, 32'hC3, 1'b1);
    chk("R2 hidden", 32'(tx_valid), 32'd0);
    // R3: commit three
    op(1'b1, 12'h804, 32'd3, 1'b0);
    chk("R3 fill+wptr", bus_rdata, 32'h0003_0003);
    // R7: drain in order
    op(1'b0, 12'h804, 32'd0, 1'b1);
    op(1'b0, 12'h804, 32'd0, 1'b1);
    op(1'b0, 12'h804, 32'd0, 1'b1);
    chk("R7 drained", 32'(tx_empty), 32'd1);

    // fill every free slot, then R4 oversize commit
    for (int k = 0; k < DEPTH - 1; k++) op(1'b1, 12'h400 + 12'(k), 32'(k * 7 + 1), 1'b0);
    op(1'b1, 12'h804, 32'd1023, 1'b0);
    chk("R4 clamp", bus_rdata, (32'(DEPTH - 1) << 16) | 32'((3 + DEPTH - 1) % DEPTH));
    // R5: write while full is dropped; R4 further commit adds nothing
    op(1'b1, 12'h400, 32'hEE, 1'b0);
    op(1'b1, 12'h804, 32'd5, 1'b0);
    chk("R5 full hold", bus_rdata, (32'(DEPTH - 1) << 16) | 32'((3 + DEPTH - 1) % DEPTH));
    // R10: commit with drain in same cycle
    op(1'b0, 12'h804, 32'd0, 1'b1);
    op(1'b1, 12'h400, 32'h5A, 1'b0);
    op(1'b1, 12'h804, 32'd1, 1'b1);
    chk("R10 fill", bus_rdata[31:16], 32'(DEPTH - 2));
    // R6: other address reads zero
    bus_addr = 12'h808; #1;
    chk("R6 other addr", bus_rdata, 32'd0);
    bus_addr = 12'h804;

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int r;
      int fr;
      r  = int'($urandom % 10);
      fr = DEPTH - 1 - m_fill;
      if (r < 5) op(1'b1, 12'h400 + 12'($urandom % (fr + 4)), $urandom, 1'($urandom));
      else if (r < 7) op(1'b1, 12'h804, ($urandom % 4 == 0) ? 32'($urandom % 1024) : 32'($urandom % 9), 1'($urandom));
      else op(1'b0, 12'h804, 32'd0, ($urandom % 3) != 0);
    end
    while (m_fill != 0) op(1'b0, 12'h804, 32'd0, 1'b1);
    chk("R8 final empty", 32'(tx_empty), 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule